// File: doc/BRIEF.md
# SHA-1 Four-Round Step Unit

This block advances a SHA-1 working state by four compression rounds per transaction. The caller supplies the 128-bit state (A, B, C, D) and a 128-bit word bundle. The bundle holds the message words for the four rounds, and its first word already has state variable E added to it. A group selector chooses the round function and the additive constant, and that choice applies to all four rounds. The result is the updated A, B, C and D. The final E is discarded.

Input and output each use a valid/ready handshake. A single register stage holds the result. Message expansion, producing E for the next group, padding and the final digest addition are left to the surrounding logic. A caller hashing a block issues twenty transactions: five in each group.

Top module: `sha1q_step_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `outValid` is 0.
- R2: `inReady` is 1 exactly when `outValid` is 0 or `outReady` is 1.
- R3: An input accepted at a clock edge (`inValid` and `inReady` both 1) appears on `outState`, with `outValid` = 1, after that same edge. If no new input is accepted while the result is taken, `outValid` falls after the edge that takes it.
- R4: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outState` does not change, even if `inValid` is high.
- R5: Group code 0 uses the choose function (B AND C) OR (NOT B AND D) with constant 32'h5A827999.
- R6: Group code 1 uses the parity function B XOR C XOR D with constant 32'h6ED9EBA1.
- R7: Group code 2 uses the majority of B, C and D with constant 32'h8F1BBCDC.
- R8: Group code 3 uses the parity function with constant 32'hCA62C1D6.
- R9: Only `inGroup[1:0]` selects the group. Bits 7:2 do not change the result.
- R10: State packing is A in [127:96], B in [95:64], C in [63:32] and D in [31:0], for both input and output. The message words occupy [127:96] for the E-summed first word, then [95:64], [63:32] and [31:0] for rounds two to four.
- R11: Each round computes newA = f(B,C,D) + rol5(A) + word + Eterm + K modulo 2^32, then sets B=A, C=rol30(B), D=C and E=D. Eterm is 0 in round one and the previous round's D in rounds two to four.
- R12: When `outReady` is 1 while `outValid` is 1, a new input is accepted in the same cycle. Transactions can therefore follow each other with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input transaction offered |
| inReady | output | 1 | Unit can take an input |
| inState | input | 128 | Working state A,B,C,D |
| inMsg | input | 128 | Four round words, first pre-summed with E |
| inGroup | input | 8 | Round group code (bits 1:0 used) |
| outValid | output | 1 | Result held |
| outReady | input | 1 | Consumer takes result |
| outState | output | 128 | Updated state A,B,C,D |

## Verification
The hardest case to reach is a replacement under back-pressure. In that case a second transaction waits while the first result is stalled. The release of `outReady` must then drain the old result and load the new one at the same edge. The bench stalls the output for several cycles with a second input already asserted. It confirms that nothing is overwritten during the stall and that the new result lands exactly one edge after release. The E-chain (rounds two to four adding the prior D, round one adding nothing) can only be seen through the final state. The bench therefore uses vectors that are nonzero only in single words, together with full-ones vectors that force every addition to wrap.

// File: rtl/sha1q_pkg.sv
package sha1q_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 4;
  localparam int STATE_W   = WORD_W * NUM_WORDS;
  localparam int GROUP_W   = 8;
  localparam int CODE_W    = 2;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [CODE_W-1:0] {
    GRP_CHOOSE = 2'd0,
    GRP_PAR_A  = 2'd1,
    GRP_MAJ    = 2'd2,
    GRP_PAR_B  = 2'd3
  } group_e;

  typedef struct packed {
    logic load;
    logic drain;
  } ctrl_strobes_t;

  function automatic word_t roundLogic(group_e g, word_t b, word_t c, word_t d);
    case (g)
      GRP_CHOOSE: roundLogic = (b & c) | (~b & d);
      GRP_MAJ:    roundLogic = (b & c) | (b & d) | (c & d);
      default:    roundLogic = b ^ c ^ d;
    endcase
  endfunction

  function automatic word_t roundConst(group_e g);
    case (g)
      GRP_CHOOSE: roundConst = 32'h5A827999;
      GRP_PAR_A:  roundConst = 32'h6ED9EBA1;
      GRP_MAJ:    roundConst = 32'h8F1BBCDC;
      default:    roundConst = 32'hCA62C1D6;
    endcase
  endfunction

  function automatic word_t rotl(word_t x, int unsigned n);
    rotl = (x << n) | (x >> (WORD_W - n));
  endfunction
endpackage

// File: rtl/sha1q_ctrl.sv
module sha1q_ctrl
  import sha1q_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inValid,
  input  logic          outReady,
  output logic          inReady,
  output logic          outValid,
  output ctrl_strobes_t strobes
);
  logic validQ;

  always_comb begin
    inReady       = !validQ || outReady;
    strobes.load  = inValid && inReady;
    strobes.drain = validQ && outReady;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               validQ <= 1'b0;
    else if (strobes.load)    validQ <= 1'b1;
    else if (strobes.drain)   validQ <= 1'b0;
  end

  assign outValid = validQ;
endmodule

// File: rtl/sha1q_datapath.sv
module sha1q_datapath
  import sha1q_pkg::*;
(
  input  logic               clk,
  input  ctrl_strobes_t      strobes,
  input  logic [STATE_W-1:0] inState,
  input  logic [STATE_W-1:0] inMsg,
  input  logic [GROUP_W-1:0] inGroup,
  output logic [STATE_W-1:0] outState
);
  group_e grp;
  word_t  kConst;
  word_t  aS [0:NUM_WORDS];
  word_t  bS [0:NUM_WORDS];
  word_t  cS [0:NUM_WORDS];
  word_t  dS [0:NUM_WORDS];
  word_t  eS [0:NUM_WORDS];
  logic [STATE_W-1:0] resultQ;

  assign grp    = group_e'(inGroup[CODE_W-1:0]);
  assign kConst = roundConst(grp);

  assign aS[0] = inState[STATE_W-1 -: WORD_W];
  assign bS[0] = inState[STATE_W-1-WORD_W -: WORD_W];
  assign cS[0] = inState[STATE_W-1-2*WORD_W -: WORD_W];
  assign dS[0] = inState[WORD_W-1:0];
  assign eS[0] = '0;

  for (genvar r = 0; r < NUM_WORDS; r++) begin : g_round
    word_t msgWord;
    word_t fVal;
    assign msgWord = inMsg[STATE_W-1-r*WORD_W -: WORD_W];
    assign fVal    = roundLogic(grp, bS[r], cS[r], dS[r]);
    assign aS[r+1] = fVal + rotl(aS[r], 5) + msgWord + eS[r] + kConst;
    assign bS[r+1] = aS[r];
    assign cS[r+1] = rotl(bS[r], 30);
    assign dS[r+1] = cS[r];
    assign eS[r+1] = dS[r];
  end

  always_ff @(posedge clk) begin
    if (strobes.load)
      resultQ <= {aS[NUM_WORDS], bS[NUM_WORDS], cS[NUM_WORDS], dS[NUM_WORDS]};
  end

  assign outState = resultQ;
endmodule

// File: rtl/sha1q_step_unit.sv
module sha1q_step_unit
  import sha1q_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  output logic               inReady,
  input  logic [STATE_W-1:0] inState,
  input  logic [STATE_W-1:0] inMsg,
  input  logic [GROUP_W-1:0] inGroup,
  output logic               outValid,
  input  logic               outReady,
  output logic [STATE_W-1:0] outState
);
  ctrl_strobes_t strobes;

  sha1q_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobes  (strobes)
  );

  sha1q_datapath dp_i (
    .clk      (clk),
    .strobes  (strobes),
    .inState  (inState),
    .inMsg    (inMsg),
    .inGroup  (inGroup),
    .outState (outState)
  );
endmodule

// File: rtl/sha1q_checker.sv
module sha1q_checker
  import sha1q_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               inValid,
  input logic               inReady,
  input logic               outValid,
  input logic               outReady,
  input logic [STATE_W-1:0] outState
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> !outValid); // R1
  AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |-> !inReady); // R2
  AST_READY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!outValid || outReady) |-> inReady); // R2
  AST_LOAD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> outValid); // R3
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outReady && !inValid) |=> !outValid); // R3
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outState))); // R4
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outReady) |-> inReady); // R12
endmodule

bind sha1q_step_unit sha1q_checker chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outState (outState)
);

// File: tb/sha1q_step_unit_tb_top.sv
module sha1q_step_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [127:0] inState = '0;
  logic [127:0] inMsg = '0;
  logic [7:0]   inGroup = '0;
  logic         outValid;
  logic         outReady = 1'b0;
  logic [127:0] outState;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sha1q_step_unit dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inState(inState), .inMsg(inMsg), .inGroup(inGroup),
    .outValid(outValid), .outReady(outReady), .outState(outState)
  );

  function automatic logic [31:0] rl(logic [31:0] x, int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [127:0] refModel(logic [127:0] s, logic [127:0] m, logic [7:0] g);
    logic [31:0] a, b, c, d, e, f, k, w, t;
    a = s[127:96]; b = s[95:64]; c = s[63:32]; d = s[31:0]; e = 0;
    case (g[1:0])
      2'd0: k = 32'h5A827999;
      2'd1: k = 32'h6ED9EBA1;
      2'd2: k = 32'h8F1BBCDC;
      default: k = 32'hCA62C1D6;
    endcase
    for (int r = 0; r < 4; r++) begin
      w = m[127 - 32*r -: 32];
      if (g[1:0] == 2'd0)      f = (b & c) | (~b & d);
      else if (g[1:0] == 2'd2) f = (b & c) | (b & d) | (c & d);
      else                     f = b ^ c ^ d;
      t = f + rl(a, 5) + w + k + ((r == 0) ? 32'd0 : e);
      e = d; d = c; c = rl(b, 30); b = a; a = t;
    end
    return {a, b, c, d};
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one transaction with the output consumer always ready
  task automatic runOp(logic [127:0] s, logic [127:0] m, logic [7:0] g, string req);
    logic [127:0] exp;
    exp = refModel(s, m, g);
    @(negedge clk);
    inState = s; inMsg = m; inGroup = g; inValid = 1; outReady = 1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 0;
    check(outValid === 1'b1, req, {127'd0, outValid}, 128'd1);
    check(outState === exp, req, outState, exp);
    @(negedge clk);
  endtask

  task automatic testReset();
    check(outValid === 1'b0, "R1", {127'd0, outValid}, 128'd0);
    check(inReady === 1'b1, "R2", {127'd0, inReady}, 128'd1);
  endtask

  task automatic testGroups();
    logic [127:0] s, m;
    s = 128'h67452301_EFCDAB89_98BADCFE_10325476;
    m = 128'h11111111_22222222_33333333_44444444;
    runOp(s, m, 8'd0, "R5");
    runOp(s, m, 8'd1, "R6");
    runOp(s, m, 8'd2, "R7");
    runOp(s, m, 8'd3, "R8");
    // known value: zero state and words, group 1 -> round one A equals K1
    runOp('0, '0, 8'd1, "R6");
  endtask

  task automatic testHighBits();
    logic [127:0] s, m, r0, r1;
    s = 128'hDEADBEEF_01234567_89ABCDEF_CAFEF00D;
    m = 128'h0BADF00D_12345678_9ABCDEF0_55AA55AA;
    for (int gi = 0; gi < 4; gi++) begin
      runOp(s, m, 8'(gi), "R9");
      r0 = outState;
      runOp(s, m, 8'hFC | 8'(gi), "R9");
      r1 = outState;
      check(r0 === r1, "R9", r1, r0);
    end
  endtask

  task automatic testPacking();
    // single nonzero words expose word order and the E chain
    runOp(128'h0, 128'h00000001_00000000_00000000_00000000, 8'd2, "R10");
    runOp(128'h0, 128'h00000000_00000000_00000000_00000001, 8'd2, "R10");
    runOp(128'h00000000_00000000_00000000_80000000, 128'h0, 8'd3, "R11");
    runOp(128'h00000000_00000000_00000000_00000005, 128'h0, 8'd0, "R11");
    runOp('1, '1, 8'd0, "R11");
    runOp('1, '1, 8'd2, "R11");
  endtask

  task automatic testBackpressure();
    logic [127:0] s1, s2, m, e1, e2;
    s1 = 128'h01020304_05060708_090A0B0C_0D0E0F10;
    s2 = 128'hF0E0D0C0_B0A09080_70605040_30201000;
    m  = 128'hA5A5A5A5_5A5A5A5A_C3C3C3C3_3C3C3C3C;
    e1 = refModel(s1, m, 8'd1);
    e2 = refModel(s2, m, 8'd2);
    @(negedge clk);
    outReady = 0; inState = s1; inMsg = m; inGroup = 8'd1; inValid = 1;
    @(negedge clk);
    inState = s2; inGroup = 8'd2;
    check(outValid === 1'b1, "R3", {127'd0, outValid}, 128'd1);
    check(inReady === 1'b0, "R2", {127'd0, inReady}, 128'd0);
    for (int i = 0; i < 3; i++) @(negedge clk);
    check(outValid === 1'b1, "R4", {127'd0, outValid}, 128'd1);
    check(outState === e1, "R4", outState, e1);
    outReady = 1;
    #1;
    check(inReady === 1'b1, "R12", {127'd0, inReady}, 128'd1);
    @(negedge clk);
    inValid = 0;
    check(outValid === 1'b1, "R12", {127'd0, outValid}, 128'd1);
    check(outState === e2, "R12", outState, e2);
    @(negedge clk);
    check(outValid === 1'b0, "R3", {127'd0, outValid}, 128'd0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1;
    @(negedge clk);
    check(outValid === 1'b0, "R1", {127'd0, outValid}, 128'd0);
    testGroups();
    testHighBits();
    testPacking();
    testBackpressure();
    finish();
  end
endmodule